// File: doc/BRIEF.md
# Vector Interleave, Unzip and Transpose Permute Unit

This block rearranges the elements of two source vectors into one destination vector for a scalable vector datapath. Six two-source permutes are offered: an interleave that takes the low or the high half of both sources, a de-interleave that gathers the even-indexed or odd-indexed elements of the concatenated sources, and a transpose that takes the even or odd members of each element pair. Elements may be 8, 16, 32, 64 or 128 bits wide. The vector length at run time is a count of 128-bit granules, bounded by the parameter `MAX_VL_BITS`.

With 128-bit elements the active vector may hold an odd number of elements. Only the whole pairs then take part in the permute, and the final destination element is written as zero. A vector with fewer than two active elements cannot be permuted; the operation is flagged undefined and gives an all-zero result. A single register stage holds the result and the flag, with a valid handshake.

Top module: `vperm_unit`

## Requirements
- R1: Element i of a vector lies in bits [i*EW +: EW], with element 0 at the least significant end. Outside wide mode, `size_code` 0/1/2/3 selects EW = 8/16/32/64, and `op` 0/1 are interleave low/high, 2/3 are de-interleave even/odd, and 4/5 are transpose even/odd. For these opcodes `undef` stays low when `gran` is at least 1.
- R2: When `wide` is 1, EW is 128 whatever `size_code` holds. Opcodes 0 to 3 keep their meaning from R1, while 6 is transpose even and 7 is transpose odd.
- R3: Let N be the active element count and P = floor(N/2). For interleave, with h = 0 for low and 1 for high, dest[2i] = A[i+h*P] and dest[2i+1] = B[i+h*P] for i from 0 to P-1.
- R4: For de-interleave, with h = 0 for even and 1 for odd, let S be A's elements 0 to 2P-1 followed by B's elements 0 to 2P-1. Then dest[i] = S[2i+h] for i from 0 to 2P-1.
- R5: For transpose, with h = 0 for even and 1 for odd, dest[2i] = A[2i+h] and dest[2i+1] = B[2i+h] for i from 0 to P-1.
- R6: Any destination element with index 2P or higher is zero. With 128-bit elements and an odd granule count, the last active element is therefore zero.
- R7: Result bits at or above `gran`*128 are zero.
- R8: If N is below 2, the result is all zeros and `undef` is 1. This happens with `wide` set and `gran` of 0 or 1.
- R9: Opcodes 6 and 7 outside wide mode, and opcodes 4 and 5 in wide mode, set `undef` to 1 and give an all-zero result.
- R10: `result` and `undef` are captured together on a clock edge where `valid_in` is 1. `valid_out` is 1 for exactly the cycle after that edge. Without `valid_in`, both outputs hold their values. In reset, `valid_out`, `result` and `undef` are all 0.
- R11: A `gran` value above MAX_VL_BITS/128 is treated as MAX_VL_BITS/128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operands and controls are valid this cycle |
| op | input | 3 | Permute selector (R1, R2) |
| size_code | input | 2 | Element size selector when not in wide mode |
| wide | input | 1 | Forces 128-bit elements and the wide opcode map |
| gran | input | $clog2(MAX_VL_BITS/128+1) | Active vector length in 128-bit granules |
| src_a | input | MAX_VL_BITS | First source vector |
| src_b | input | MAX_VL_BITS | Second source vector |
| valid_out | output | 1 | Result is presented this cycle |
| result | output | MAX_VL_BITS | Destination vector |
| undef | output | 1 | Operation undefined; result forced to zero |

## Verification
Every result and its `undef` flag are due one clock edge after the `valid_in` edge that carries the operands, and `valid_out` must fall again on the following edge. The bench drives each operation on a falling edge and removes `valid_in` on the next falling edge. It compares `valid_out`, `undef` and `result` at that falling edge, which lies half a period after the capturing rising edge. It then waits one more falling edge to confirm that `valid_out` is low and that the outputs have held.

// File: rtl/vperm_pkg.sv
package vperm_pkg;
   // Class of permute chosen by the opcode decoder
   typedef enum logic [1:0] {
      PK_ZIP  = 2'd0,
      PK_UZP  = 2'd1,
      PK_TRN  = 2'd2,
      PK_NONE = 2'd3
   } perm_kind_t;

   localparam int GRAN_BITS = 128;
   localparam int NUM_SIZES = 5;
endpackage

// File: rtl/vperm_decode.sv
module vperm_decode
   import vperm_pkg::*;
(
   input  logic [2:0]  op,
   input  logic        wide,
   output perm_kind_t  kind,
   output logic        part,
   output logic        bad
);
   always_comb begin
      kind = PK_NONE;
      part = op[0];
      if (wide) begin
         unique case (op)
            3'd0, 3'd1: kind = PK_ZIP;
            3'd2, 3'd3: kind = PK_UZP;
            3'd6, 3'd7: kind = PK_TRN;
            default:    kind = PK_NONE;
         endcase
      end else begin
         unique case (op)
            3'd0, 3'd1: kind = PK_ZIP;
            3'd2, 3'd3: kind = PK_UZP;
            3'd4, 3'd5: kind = PK_TRN;
            default:    kind = PK_NONE;
         endcase
      end
      bad = (kind == PK_NONE);
   end
endmodule

// File: rtl/vperm_lanes.sv
module vperm_lanes
   import vperm_pkg::*;
#(
   parameter int VL_BITS = 512,
   parameter int EW      = 8,
   parameter int GW      = 3
) (
   input  logic [VL_BITS-1:0] a,
   input  logic [VL_BITS-1:0] b,
   input  perm_kind_t         kind,
   input  logic               part,
   input  logic [GW-1:0]      gran,
   output logic [VL_BITS-1:0] y,
   output logic               too_short
);
   localparam int NE  = VL_BITS / EW;
   localparam int EPG = GRAN_BITS / EW;
   localparam int LW  = (NE > 1) ? $clog2(NE) : 1;

   logic [EW-1:0] ea [NE];
   logic [EW-1:0] eb [NE];
   int ecnt, half, paired;

   always_comb begin
      ecnt   = int'(gran) * EPG;
      half   = ecnt / 2;
      paired = half * 2;
   end

   assign too_short = (ecnt < 2);

   for (genvar j = 0; j < NE; j++) begin : g_unpack
      assign ea[j] = a[j*EW +: EW];
      assign eb[j] = b[j*EW +: EW];
   end

   for (genvar i = 0; i < NE; i++) begin : g_dest
      logic [EW-1:0] elem;
      always_comb begin
         int k;
         k    = 0;
         elem = '0;
         if (i < paired) begin
            unique case (kind)
               PK_ZIP: begin
                  k    = (i / 2) + (part ? half : 0);
                  elem = (i % 2 == 0) ? ea[LW'(k)] : eb[LW'(k)];
               end
               PK_UZP: begin
                  k = 2 * i + int'(part);
                  if (k < paired) elem = ea[LW'(k)];
                  else            elem = eb[LW'(k - paired)];
               end
               PK_TRN: begin
                  k    = (i - (i % 2)) + int'(part);
                  elem = (i % 2 == 0) ? ea[LW'(k)] : eb[LW'(k)];
               end
               default: elem = '0;
            endcase
         end
      end
      assign y[i*EW +: EW] = elem;
   end
endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
   import vperm_pkg::*;
#(
   parameter  int MAX_VL_BITS = 512,
   localparam int GW          = $clog2(MAX_VL_BITS / 128 + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   valid_in,
   input  logic [2:0]             op,
   input  logic [1:0]             size_code,
   input  logic                   wide,
   input  logic [GW-1:0]          gran,
   input  logic [MAX_VL_BITS-1:0] src_a,
   input  logic [MAX_VL_BITS-1:0] src_b,
   output logic                   valid_out,
   output logic [MAX_VL_BITS-1:0] result,
   output logic                   undef
);
   localparam int MAX_GRAN = MAX_VL_BITS / GRAN_BITS;

   if ((MAX_VL_BITS % GRAN_BITS) != 0 || MAX_VL_BITS < 2 * GRAN_BITS) begin : g_bad_cfg
      $error("vperm_unit: MAX_VL_BITS must be a multiple of 128 and at least 256");
   end

   perm_kind_t kind;
   logic       part, bad_op;
   logic [GW-1:0] gran_eff;

   assign gran_eff = (int'(gran) > MAX_GRAN) ? GW'(MAX_GRAN) : gran;

   vperm_decode u_dec (
      .op   (op),
      .wide (wide),
      .kind (kind),
      .part (part),
      .bad  (bad_op)
   );

   logic [MAX_VL_BITS-1:0] lane_y     [NUM_SIZES];
   logic                   lane_short [NUM_SIZES];

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      vperm_lanes #(
         .VL_BITS (MAX_VL_BITS),
         .EW      (8 << s),
         .GW      (GW)
      ) u_lanes (
         .a         (src_a),
         .b         (src_b),
         .kind      (kind),
         .part      (part),
         .gran      (gran_eff),
         .y         (lane_y[s]),
         .too_short (lane_short[s])
      );
   end

   logic [MAX_VL_BITS-1:0] sel_y;
   logic                   sel_short, undef_d;

   always_comb begin
      if (wide) begin
         sel_y     = lane_y[4];
         sel_short = lane_short[4];
      end else begin
         unique case (size_code)
            2'd0:    begin sel_y = lane_y[0]; sel_short = lane_short[0]; end
            2'd1:    begin sel_y = lane_y[1]; sel_short = lane_short[1]; end
            2'd2:    begin sel_y = lane_y[2]; sel_short = lane_short[2]; end
            default: begin sel_y = lane_y[3]; sel_short = lane_short[3]; end
         endcase
      end
      undef_d = bad_op | sel_short;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_out <= 1'b0;
         result    <= '0;
         undef     <= 1'b0;
      end else begin
         valid_out <= valid_in;
         if (valid_in) begin
            result <= undef_d ? '0 : sel_y;
            undef  <= undef_d;
         end
      end
   end
endmodule

// File: rtl/vperm_unit_chk.sv
module vperm_unit_chk #(
   parameter  int MAX_VL_BITS = 512,
   localparam int GW          = $clog2(MAX_VL_BITS / 128 + 1)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   valid_in,
   input logic [2:0]             op,
   input logic                   wide,
   input logic [GW-1:0]          gran,
   input logic                   valid_out,
   input logic [MAX_VL_BITS-1:0] result,
   input logic                   undef
);
   localparam int MAX_GRAN = MAX_VL_BITS / 128;

   logic [GW-1:0]          gran_q;
   logic [MAX_VL_BITS-1:0] live_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gran_q <= '0;
      else if (valid_in) gran_q <= gran;
   end

   always_comb begin
      int lim;
      lim = (int'(gran_q) > MAX_GRAN) ? MAX_GRAN : int'(gran_q);
      for (int bt = 0; bt < MAX_VL_BITS; bt++) live_mask[bt] = (bt < lim * 128);
   end

   // R10
   vout_follows_vin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |=> valid_out);
   // R10
   vout_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> !valid_out);
   // R10
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> ($stable(result) && $stable(undef)));
   // R8
   short_vector_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && wide && gran < 2) |=> (undef && result == '0));
   // R9
   bad_opcode_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && (wide ? (op[2:1] == 2'b10) : (op[2:1] == 2'b11))) |=> (undef && result == '0));
   // R1
   legal_small_defined_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && !wide && op[2:1] != 2'b11 && gran != '0) |=> !undef);
   // R7
   tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_out |-> ((result & ~live_mask) == '0));
endmodule

bind vperm_unit vperm_unit_chk #(.MAX_VL_BITS(MAX_VL_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .valid_in  (valid_in),
   .op        (op),
   .wide      (wide),
   .gran      (gran),
   .valid_out (valid_out),
   .result    (result),
   .undef     (undef)
);

// File: tb/vperm_unit_bench.sv
module vperm_unit_bench;
   localparam int VL = 512;
   localparam int GW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          valid_in = 1'b0;
   logic [2:0]    op = '0;
   logic [1:0]    size_code = '0;
   logic          wide = 1'b0;
   logic [GW-1:0] gran = '0;
   logic [VL-1:0] src_a = '0, src_b = '0;
   logic          valid_out, undef;
   logic [VL-1:0] result;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   vperm_unit #(.MAX_VL_BITS(VL)) u_vperm_unit (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op),
      .size_code(size_code), .wide(wide), .gran(gran),
      .src_a(src_a), .src_b(src_b),
      .valid_out(valid_out), .result(result), .undef(undef)
   );

   typedef struct packed {
      logic [2:0] op;
      logic [1:0] sz;
      logic       wd;
      logic [2:0] gr;
      logic [7:0] seed;
   } vec_t;

   localparam int NV = 27;
   localparam vec_t TBL [NV] = '{
      // R1 R3 interleave
      '{3'd0, 2'd0, 1'b0, 3'd4, 8'd1},
      '{3'd1, 2'd0, 1'b0, 3'd4, 8'd2},
      '{3'd0, 2'd2, 1'b0, 3'd3, 8'd3},
      '{3'd1, 2'd3, 1'b0, 3'd2, 8'd4},
      // R4 de-interleave
      '{3'd2, 2'd1, 1'b0, 3'd4, 8'd5},
      '{3'd3, 2'd0, 1'b0, 3'd1, 8'd6},
      '{3'd3, 2'd3, 1'b0, 3'd4, 8'd7},
      // R5 transpose
      '{3'd4, 2'd0, 1'b0, 3'd4, 8'd8},
      '{3'd5, 2'd2, 1'b0, 3'd2, 8'd9},
      '{3'd5, 2'd3, 1'b0, 3'd1, 8'd10},
      // R2 R6 wide elements, odd counts
      '{3'd0, 2'd0, 1'b1, 3'd3, 8'd11},
      '{3'd1, 2'd2, 1'b1, 3'd3, 8'd12},
      '{3'd2, 2'd1, 1'b1, 3'd3, 8'd13},
      '{3'd3, 2'd3, 1'b1, 3'd4, 8'd14},
      '{3'd6, 2'd0, 1'b1, 3'd3, 8'd15},
      '{3'd7, 2'd0, 1'b1, 3'd4, 8'd16},
      '{3'd7, 2'd3, 1'b1, 3'd2, 8'd17},
      // R8 too few elements
      '{3'd0, 2'd0, 1'b1, 3'd1, 8'd18},
      '{3'd6, 2'd0, 1'b1, 3'd1, 8'd19},
      '{3'd2, 2'd1, 1'b1, 3'd0, 8'd26},
      // R9 illegal opcodes
      '{3'd6, 2'd0, 1'b0, 3'd4, 8'd20},
      '{3'd7, 2'd2, 1'b0, 3'd2, 8'd21},
      '{3'd4, 2'd0, 1'b1, 3'd4, 8'd22},
      '{3'd5, 2'd1, 1'b1, 3'd3, 8'd23},
      // R11 clamp of granule count
      '{3'd2, 2'd0, 1'b0, 3'd7, 8'd24},
      '{3'd7, 2'd0, 1'b1, 3'd6, 8'd25},
      '{3'd1, 2'd1, 1'b0, 3'd5, 8'd27}
   };

   function automatic logic [VL-1:0] mkdata(input logic [7:0] seed, input int which);
      logic [VL-1:0] v;
      v = '0;
      for (int j = 0; j < VL / 8; j++) v[j*8 +: 8] = 8'(int'(seed) * 13 + j * 7 + which * 8'h55);
      return v;
   endfunction

   function automatic logic [127:0] get_el(input logic [VL-1:0] v, input int idx, input int ew);
      logic [VL-1:0]  t;
      logic [127:0]   m;
      t = v >> (idx * ew);
      m = (ew == 128) ? '1 : ((128'd1 << ew) - 128'd1);
      return t[127:0] & m;
   endfunction

   // Independent model written from R1..R11
   function automatic logic [VL-1:0] model(input logic [VL-1:0] a, input logic [VL-1:0] b,
                                           input vec_t v, output logic ud);
      int ew, g, n, p, kind, h;
      logic [VL-1:0]  res;
      logic [127:0]   el;
      ew = v.wd ? 128 : (8 << v.sz);
      g  = (int'(v.gr) > VL / 128) ? VL / 128 : int'(v.gr);
      n  = g * 128 / ew;
      p  = n / 2;
      h  = int'(v.op[0]);
      if (v.wd) kind = (v.op < 4) ? int'(v.op) / 2 : (v.op >= 6 ? 2 : 3);
      else      kind = (v.op < 6) ? int'(v.op) / 2 : 3;
      ud  = (kind == 3) || (n < 2);
      res = '0;
      if (!ud) begin
         for (int i = 0; i < 2 * p; i++) begin
            case (kind)
               0: el = (i % 2 == 0) ? get_el(a, i / 2 + h * p, ew) : get_el(b, i / 2 + h * p, ew);
               1: begin
                  int s;
                  s  = 2 * i + h;
                  el = (s >= 2 * p) ? get_el(b, s - 2 * p, ew) : get_el(a, s, ew);
               end
               default: el = (i % 2 == 0) ? get_el(a, 2 * (i / 2) + h, ew)
                                          : get_el(b, 2 * (i / 2) + h, ew);
            endcase
            res = res | (VL'(el) << (i * ew));
         end
      end
      return res;
   endfunction

   task automatic chk(input string req, input logic [VL-1:0] act, input logic [VL-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic issue(input vec_t v);
      op = v.op; size_code = v.sz; wide = v.wd; gran = v.gr;
      src_a = mkdata(v.seed, 0); src_b = mkdata(v.seed, 1);
      valid_in = 1'b1;
      @(negedge clk);
      valid_in = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [VL-1:0] exp_r, exp_r2, prev;
      logic          exp_u, exp_u2;
      vec_t          v2;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 reset valid_out", VL'(valid_out), '0);
      chk("R10 reset result", result, '0);
      chk("R10 reset undef", VL'(undef), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 idle after reset", VL'(valid_out), '0);

      for (int t = 0; t < NV; t++) begin
         exp_r = model(mkdata(TBL[t].seed, 0), mkdata(TBL[t].seed, 1), TBL[t], exp_u);
         issue(TBL[t]);
         chk($sformatf("R10 valid_out vec %0d", t), VL'(valid_out), VL'(1));
         chk($sformatf("R1-model undef vec %0d (R8 R9)", t), VL'(undef), VL'(exp_u));
         chk($sformatf("R3 R4 R5 R6 R7 R11 result vec %0d", t), result, exp_r);
         prev = result;
         @(negedge clk);
         chk($sformatf("R10 single pulse vec %0d", t), VL'(valid_out), '0);
         chk($sformatf("R10 hold vec %0d", t), result, prev);
      end

      // R2: size code has no effect in wide mode
      v2 = '{3'd0, 2'd3, 1'b1, 3'd3, 8'd11};
      exp_r = model(mkdata(8'd11, 0), mkdata(8'd11, 1), '{3'd0, 2'd0, 1'b1, 3'd3, 8'd11}, exp_u);
      issue(v2);
      chk("R2 size code ignored when wide", result, exp_r);
      // R6: top granule element of odd wide vector is zero
      chk("R6 last odd element zero", VL'(get_el(result, 2, 128)), '0);

      // R10 back-to-back issues
      v2 = '{3'd4, 2'd1, 1'b0, 3'd4, 8'd30};
      exp_r  = model(mkdata(8'd30, 0), mkdata(8'd30, 1), v2, exp_u);
      exp_r2 = model(mkdata(8'd31, 0), mkdata(8'd31, 1), '{3'd1, 2'd2, 1'b0, 3'd4, 8'd31}, exp_u2);
      op = v2.op; size_code = v2.sz; wide = v2.wd; gran = v2.gr;
      src_a = mkdata(8'd30, 0); src_b = mkdata(8'd30, 1); valid_in = 1'b1;
      @(negedge clk);
      chk("R10 b2b first valid", VL'(valid_out), VL'(1));
      chk("R5 b2b first result", result, exp_r);
      op = 3'd1; size_code = 2'd2; src_a = mkdata(8'd31, 0); src_b = mkdata(8'd31, 1);
      @(negedge clk);
      valid_in = 1'b0;
      chk("R10 b2b second valid", VL'(valid_out), VL'(1));
      chk("R3 b2b second result", result, exp_r2);
      chk("R1 b2b second undef", VL'(undef), VL'(exp_u2));
      @(negedge clk);
      chk("R10 b2b ends", VL'(valid_out), '0);

      // R10 idle inputs change without valid_in: outputs hold
      prev = result;
      src_a = '1; op = 3'd6; wide = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10 hold idle result", result, prev);
      chk("R10 hold idle undef", VL'(undef), VL'(exp_u2));

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule